// File: doc/BRIEF.md
# Motor Stall Guard

This block supervises a brushless motor commutation path for a stalled rotor. While the drive stage reports that the motor is being driven, it counts clock cycles during which the three-bit Hall sensor code stays the same. If that count reaches a programmable limit, the block latches a stall fault and asserts a kill request for the low-side gate drivers. The same block merges the stall fault with undervoltage, overtemperature and invalid-sensor indications into a single active-low fail flag.

A latched stall is released in three ways. A functional reset request clears it. An undervoltage condition also clears it, because undervoltage forces the reset condition. It also clears after the commanded duty has been held at zero for twice the stall limit without interruption. While either reset or undervoltage is present, a separate gate-off output tells the drive stage to switch off every gate. The timeout is a digital counter limit given on a port, so firmware or strap logic sets it in clock cycles. The Hall code can pass through a configurable number of synchronizer stages before change detection.

Top module: `stall_guard`

## Requirements
- R1: After asynchronous reset (rst_n low), lowside_kill is 0, and with no fault inputs high, fail_n is 1 and gate_off is 0.
- R2: When drive_en is high and the synchronized Hall code is unchanged for stall_limit consecutive clock edges, lowside_kill goes to 1 after the last of those edges and stays 1 until released.
- R3: Any change of the synchronized Hall code (any bit differing from the previous synchronized value) restarts the stall count, so Hall changes spaced closer than stall_limit cycles never latch a stall.
- R4: While drive_en is low, the stall count is held at zero and a stall cannot latch.
- R5: A latched stall is released after 2*stall_limit consecutive clock edges with duty_zero high. lowside_kill returns to 0 after the last of those edges.
- R6: A clock edge with duty_zero low while the stall is latched restarts the release count from zero.
- R7: ctl_reset or uv_flag high at a clock edge clears the stall latch and both counts. gate_off equals ctl_reset OR uv_flag without delay.
- R8: fail_n is 0 exactly when the stall latch is set or any of uv_flag, ot_flag, hall_bad is high. The three external sources act without delay and are not latched.
- R9: hall_in passes through SYNC_STAGES clocked stages, all reset to 0, before change detection. The first synchronized value is compared against a reset value of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| stall_limit | input | CNT_W | Stall timeout in clock cycles; the release window is twice this |
| hall_in | input | HALL_W | Raw Hall sensor code |
| drive_en | input | 1 | High while the motor is being driven |
| duty_zero | input | 1 | High while the commanded PWM duty is 0% |
| ctl_reset | input | 1 | Functional reset request, synchronous |
| uv_flag | input | 1 | Undervoltage detected |
| ot_flag | input | 1 | Overtemperature detected |
| hall_bad | input | 1 | Invalid Hall code detected |
| lowside_kill | output | 1 | Turns off all low-side gate drives while a stall is latched |
| gate_off | output | 1 | Turns off all gate drives during reset or undervoltage |
| fail_n | output | 1 | Active-low combined fault flag |

## Verification
The bench builds the block with CNT_W = 6 and SYNC_STAGES = 2. The narrow counter makes the largest stall limit (63 cycles) and its 126-cycle release window short enough to run in full, next to limits of 1 and 5. The two synchronizer stages make the Hall latency visible, so the cycle on which a stall latches after the last Hall change shows up in the cycle-by-cycle comparison against the reference model.

// File: rtl/stall_pkg.sv
package stall_pkg;

   typedef struct packed {
      logic stall;
      logic undervolt;
      logic overtemp;
      logic sensor;
   } fault_vec_t;

   function automatic logic any_fault(input fault_vec_t v);
      return v.stall | v.undervolt | v.overtemp | v.sensor;
   endfunction

endpackage

// File: rtl/hall_change_det.sv
module hall_change_det #(
   parameter int HALL_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALL_W-1:0] hall_in,
   output logic              hall_chg
);

   logic [HALL_W-1:0] hall_s;
   logic [HALL_W-1:0] hall_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign hall_s = hall_in;
      end else begin : g_sync
         logic [HALL_W-1:0] stage_q [SYNC_STAGES];
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[0] <= '0;
                  else        stage_q[0] <= hall_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[i] <= '0;
                  else        stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign hall_s = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hall_q <= '0;
      else        hall_q <= hall_s;
   end

   assign hall_chg = (hall_s != hall_q);

endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + CNT_W'(1);
   assign expire  = ~clear & (cnt_inc >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (!expire) cnt_q <= cnt_inc;
   end

endmodule

// File: rtl/release_timer.sv
module release_timer #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);

   localparam int RW = CNT_W + 1;

   logic [RW-1:0] rc_q;
   logic [RW-1:0] rc_inc;
   logic [RW-1:0] target;

   assign target = {limit, 1'b0};
   assign rc_inc = rc_q + RW'(1);
   assign done   = run & (rc_inc >= target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rc_q <= '0;
      else if (run && !done) rc_q <= rc_inc;
      else                  rc_q <= '0;
   end

endmodule

// File: rtl/fault_merge.sv
module fault_merge (
   input  logic stall,
   input  logic uv_flag,
   input  logic ot_flag,
   input  logic hall_bad,
   input  logic ctl_reset,
   output logic gate_off,
   output logic fail_n
);

   stall_pkg::fault_vec_t fv;

   always_comb begin
      fv.stall     = stall;
      fv.undervolt = uv_flag;
      fv.overtemp  = ot_flag;
      fv.sensor    = hall_bad;
   end

   assign fail_n   = ~stall_pkg::any_fault(fv);
   assign gate_off = ctl_reset | uv_flag;

endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
   parameter int HALL_W      = 3,
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  stall_limit,
   input  logic [HALL_W-1:0] hall_in,
   input  logic              drive_en,
   input  logic              duty_zero,
   input  logic              ctl_reset,
   input  logic              uv_flag,
   input  logic              ot_flag,
   input  logic              hall_bad,
   output logic              lowside_kill,
   output logic              gate_off,
   output logic              fail_n
);

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt_w
         $error("stall_guard: CNT_W must lie in 2..31");
      end
      if (HALL_W < 1) begin : g_bad_hall_w
         $error("stall_guard: HALL_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("stall_guard: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic rst_cond;
   logic hall_chg;
   logic stall_clr;
   logic stall_exp;
   logic rel_run;
   logic rel_done;
   logic lock_q;

   assign rst_cond = ctl_reset | uv_flag;

   hall_change_det #(
      .HALL_W      (HALL_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_hall (
      .clk      (clk),
      .rst_n    (rst_n),
      .hall_in  (hall_in),
      .hall_chg (hall_chg)
   );

   assign stall_clr = rst_cond | ~drive_en | hall_chg | lock_q;

   stall_timer #(.CNT_W(CNT_W)) u_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (stall_clr),
      .limit  (stall_limit),
      .expire (stall_exp)
   );

   assign rel_run = lock_q & duty_zero & ~rst_cond;

   release_timer #(.CNT_W(CNT_W)) u_rel (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (rel_run),
      .limit (stall_limit),
      .done  (rel_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lock_q <= 1'b0;
      else if (rst_cond)  lock_q <= 1'b0;
      else if (rel_done)  lock_q <= 1'b0;
      else if (stall_exp) lock_q <= 1'b1;
   end

   assign lowside_kill = lock_q;

   fault_merge u_merge (
      .stall     (lock_q),
      .uv_flag   (uv_flag),
      .ot_flag   (ot_flag),
      .hall_bad  (hall_bad),
      .ctl_reset (ctl_reset),
      .gate_off  (gate_off),
      .fail_n    (fail_n)
   );

endmodule

// File: rtl/stall_guard_chk.sv
module stall_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic drive_en,
   input logic duty_zero,
   input logic ctl_reset,
   input logic uv_flag,
   input logic ot_flag,
   input logic hall_bad,
   input logic lowside_kill,
   input logic fail_n
);

   // R2 / R4: a stall can only latch after a driven, non-reset cycle
   a_r2_latch_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lowside_kill) |-> $past(drive_en && !ctl_reset && !uv_flag));

   // R4: with drive off and no stall, none appears at the next edge
   a_r4_idle_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_en && !lowside_kill) |=> !lowside_kill);

   // R5 / R7: release only by zero duty or a reset condition
   a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lowside_kill) |-> $past(duty_zero || ctl_reset || uv_flag));

   // R7: a reset condition leaves no stall behind
   a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_reset || uv_flag) |=> !lowside_kill);

   // R8: external faults pull the flag low at once
   a_r8_external_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_flag || ot_flag || hall_bad) |-> !fail_n);

   // R8: a latched stall also pulls the flag low
   a_r8_stall_fail: assert property (@(posedge clk) disable iff (!rst_n)
      lowside_kill |-> !fail_n);

endmodule

bind stall_guard stall_guard_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .drive_en     (drive_en),
   .duty_zero    (duty_zero),
   .ctl_reset    (ctl_reset),
   .uv_flag      (uv_flag),
   .ot_flag      (ot_flag),
   .hall_bad     (hall_bad),
   .lowside_kill (lowside_kill),
   .fail_n       (fail_n)
);

// File: tb/stall_guard_tb_top.sv
`timescale 1ns/1ps
module stall_guard_tb_top;

   localparam int HW = 3;
   localparam int CW = 6;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] lim = CW'(5);
   logic [HW-1:0] hall = '0;
   logic drv = 0, dz = 0, cr = 0, uv = 0, ot = 0, hb = 0;
   logic kill, goff, fail_n;

   int    n_vec = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    done = 0;

   // reference model state
   logic [HW-1:0] pipe_q[$];
   logic [HW-1:0] hprev;
   bit            m_lock;
   int            idle, rel;

   always #4 clk = ~clk;

   stall_guard #(.HALL_W(HW), .CNT_W(CW), .SYNC_STAGES(SS)) dut_i (
      .clk(clk), .rst_n(rst_n), .stall_limit(lim), .hall_in(hall),
      .drive_en(drv), .duty_zero(dz), .ctl_reset(cr), .uv_flag(uv),
      .ot_flag(ot), .hall_bad(hb), .lowside_kill(kill), .gate_off(goff),
      .fail_n(fail_n));

   task automatic model_reset();
      pipe_q = {};
      for (int i = 0; i < SS; i++) pipe_q.push_back('0);
      hprev = '0; m_lock = 0; idle = 0; rel = 0;
   endtask

   task automatic model_edge();
      logic [HW-1:0] hs;
      bit chg;
      hs = (pipe_q.size() == 0) ? hall : pipe_q[$];
      chg = (hs != hprev);
      hprev = hs;
      if (pipe_q.size() != 0) begin
         void'(pipe_q.pop_back());
         pipe_q.push_front(hall);
      end
      if (cr || uv) begin
         m_lock = 0; idle = 0; rel = 0;
      end else if (m_lock) begin
         idle = 0;
         if (dz) begin
            rel++;
            if (rel >= 2 * int'(lim)) begin m_lock = 0; rel = 0; end
         end else rel = 0;
      end else begin
         rel = 0;
         if (!drv || chg) idle = 0;
         else begin
            idle++;
            if (idle >= int'(lim)) begin m_lock = 1; idle = 0; end
         end
      end
   endtask

   task automatic cmp(input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cmp("lowside_kill", kill, m_lock);
         cmp("gate_off", goff, cr | uv);
         cmp("fail_n", fail_n, !(m_lock | uv | ot | hb));
         @(posedge clk);
         model_edge();
         #1;
      end
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      tag = "R1"; step(1);
      cmp("R1 reset kill", kill, 1'b0);
      cmp("R1 reset fail_n", fail_n, 1'b1);

      // R3: regular rotation, no stall
      tag = "R3"; drv = 1;
      for (int k = 0; k < 10; k++) begin
         case (k % 6)
            0: hall = 3'b001; 1: hall = 3'b011; 2: hall = 3'b010;
            3: hall = 3'b110; 4: hall = 3'b100; default: hall = 3'b101;
         endcase
         step(3);
      end

      // R2: hold the code, stall latches
      tag = "R2"; step(10);

      // R6: interrupted zero duty does not release
      tag = "R6"; dz = 1; step(6); dz = 0; step(2);

      // R5: full release window
      tag = "R5"; drv = 0; dz = 1; step(12); dz = 0;

      // R4: not driven, no stall
      tag = "R4"; step(20);

      // R9: single change, latency through the synchronizer
      tag = "R9"; drv = 1; hall = 3'b011; step(12);

      // R7: reset request and undervoltage clear the latch
      tag = "R7"; cr = 1; step(2); cr = 0; step(9);
      uv = 1; step(2); uv = 0; step(3);

      // R8: external faults
      tag = "R8"; drv = 0; ot = 1; step(2); hb = 1; step(2);
      ot = 0; step(2); hb = 0; uv = 1; step(1); uv = 0; step(2);

      // R2 / R5 at the largest limit
      tag = "R2"; lim = CW'(63); drv = 1; hall = 3'b110; step(70);
      tag = "R5"; dz = 1; step(130); dz = 0; drv = 0; step(2);

      // R3 at the smallest limit: change every cycle, then hold
      tag = "R3"; lim = CW'(1); drv = 1;
      for (int k = 0; k < 6; k++) begin
         hall = (k % 2 == 0) ? 3'b001 : 3'b010;
         step(1);
      end
      tag = "R2"; step(5);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired in %s act=running exp=finished", tag);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule